// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-driven, half-duplex SPI master for serial flash devices. Software loads three registers: a command word with the flash opcode and a 24-bit address, a 32-bit data word, and a control word that carries a transmit byte count, a receive byte count and a start bit. After a start, the engine asserts chip select and shifts out the transmit bytes in a fixed order: opcode, then address, then data. It then clocks in the receive bytes, packs them into the data word, releases chip select, waits one idle SCK period and raises a one-cycle done pulse as busy falls.

Every start carries exactly one command. The engine speaks only SPI mode 0 to a single target. Transmit and receive lengths are independent, and no receive byte is clocked before the last transmit byte has gone out. The data word is visible at all times on a read-back port, so software reads the received bytes there.

Top module: `spi_flash_engine`

## Requirements
- R1: After reset, busy and done are 0, chip select (active low) is 1, SCK is 0 and the data word reads 0.
- R2: A control write (select 2) with bit 8 set, made while idle, starts a command. Busy is 1 until the command ends. Done is high for exactly one clock, in the cycle in which busy falls.
- R3: Transmit byte k is taken from a fixed position. k=0 is command bits 7:0 (the opcode). k=1, 2 and 3 are command bits 31:24, 23:16 and 15:8 (the address, most significant byte first). k=4 to 7 are data bits 7:0, 15:8, 23:16 and 31:24. Each byte is sent MSB first in SPI mode 0: SCK idles low, MOSI changes only while SCK is low, and the target samples on the rising edge.
- R4: Receive bytes follow the last transmit byte, and MOSI is held at 0 while they are clocked. Received byte j replaces data bits 8j+7:8j, MSB first on the wire. Data bytes that are not received keep their value.
- R5: One command gives exactly 8*(transmit+receive) SCK rising edges. Chip select falls once and stays low for the whole command.
- R6: The transmit count is control bits 3:0 and is limited to 8. The receive count is control bits 7:4 and is limited to 4. Larger values act as these limits.
- R7: A start with both counts zero produces no SCK, no chip select and no busy.
- R8: Register writes made while busy are ignored. This covers the command word, the data word and the control word.
- R9: Chip select is high for 2*DIV_HALF clocks (one SCK period) before busy falls.
- R10: A control write with bit 8 clear starts nothing. Register select 0 writes the command word and select 1 writes the data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 data, 2 control |
| reg_wdata | input | 32 | Register write data |
| data_o | output | 32 | Data word read-back |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle end-of-command pulse |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest conditions to reach from the ports are a register write landing in the middle of a command, and a control word whose counts exceed the limits. Reaching them is not enough: the outcome has to be shown. The bench writes all three registers shortly after a start. It then compares the bytes captured from MOSI against the values loaded before the start, and checks that the data word still holds its earlier value. For the limit case the bench programs both count fields to 15. A behavioural flash model on the pins counts SCK edges and returns a known byte stream, so the limited length and the placement of the received bytes can be checked.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
    localparam int CMD_W      = 32;
    localparam int DATA_W     = 32;
    localparam int ADDR_BYTES = 3;
    localparam int DATA_BYTES = DATA_W / 8;
    localparam int MAX_TX     = 1 + ADDR_BYTES + DATA_BYTES;
    localparam int MAX_RX     = DATA_BYTES;
    localparam int IDX_W      = $clog2(MAX_TX + MAX_RX);
    localparam int RXI_W      = $clog2(MAX_RX);
    localparam int TXF_W      = 4;
    localparam int RXF_W      = 4;
    localparam int START_BIT  = TXF_W + RXF_W;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } fe_state_e;
endpackage

// File: rtl/spi_fe_clkdiv.sv
module spi_fe_clkdiv #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_fe_txmux.sv
module spi_fe_txmux
    import spi_fe_pkg::*;
(
    input  logic [CMD_W-1:0]  cmd,
    input  logic [DATA_W-1:0] data,
    input  logic [IDX_W-1:0]  idx,
    output logic [7:0]        tx_byte
);
    always_comb begin
        tx_byte = '0;
        if (idx == '0) tx_byte = cmd[7:0];
        for (int a = 1; a <= ADDR_BYTES; a++) begin
            if (idx == IDX_W'(a)) tx_byte = cmd[(ADDR_BYTES + 1 - a) * 8 +: 8];
        end
        for (int d = 0; d < DATA_BYTES; d++) begin
            if (idx == IDX_W'(1 + ADDR_BYTES + d)) tx_byte = data[d * 8 +: 8];
        end
    end
endmodule

// File: rtl/spi_flash_engine.sv
module spi_flash_engine
    import spi_fe_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] data_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam logic [IDX_W-1:0] MAX_TX_C = IDX_W'(MAX_TX);
    localparam logic [IDX_W-1:0] MAX_RX_C = IDX_W'(MAX_RX);

    typedef struct packed {
        fe_state_e          st;
        logic               sck;
        logic               cs_n;
        logic               done;
        logic               gap;
        logic [2:0]         bit_cnt;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   tx_n;
        logic [IDX_W-1:0]   nb;
        logic [CMD_W-1:0]   cmd;
        logic [DATA_W-1:0]  data;
        logic [7:0]         rx_sh;
    } fe_regs_t;

    fe_regs_t r_d, r_q;
    logic tick;
    logic [7:0] tx_byte;
    logic [IDX_W-1:0] tx_c, rx_c, rx_j;

    spi_fe_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (r_q.st != ST_IDLE),
        .tick (tick)
    );

    spi_fe_txmux u_mux (
        .cmd    (r_q.cmd),
        .data   (r_q.data),
        .idx    (r_q.idx),
        .tx_byte(tx_byte)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tx_c = IDX_W'(reg_wdata[TXF_W-1:0]);
        rx_c = IDX_W'(reg_wdata[TXF_W +: RXF_W]);
        if (tx_c > MAX_TX_C) tx_c = MAX_TX_C;
        if (rx_c > MAX_RX_C) rx_c = MAX_RX_C;
        rx_j = r_q.idx - r_q.tx_n;

        unique case (r_q.st)
            ST_IDLE: begin
                if (reg_we) begin
                    case (reg_sel)
                        SEL_CMD:  r_d.cmd  = reg_wdata;
                        SEL_DATA: r_d.data = reg_wdata;
                        SEL_CTRL: begin
                            if (reg_wdata[START_BIT] && (tx_c + rx_c) != '0) begin
                                r_d.st      = ST_LOW;
                                r_d.cs_n    = 1'b0;
                                r_d.bit_cnt = '0;
                                r_d.idx     = '0;
                                r_d.tx_n    = tx_c;
                                r_d.nb      = tx_c + rx_c;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_LOW: begin
                if (tick) begin
                    r_d.sck   = 1'b1;
                    r_d.rx_sh = {r_q.rx_sh[6:0], spi_miso};
                    r_d.st    = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    r_d.sck     = 1'b0;
                    r_d.bit_cnt = r_q.bit_cnt + 3'd1;
                    r_d.st      = ST_LOW;
                    if (r_q.bit_cnt == 3'd7) begin
                        if (r_q.idx >= r_q.tx_n)
                            r_d.data[rx_j[RXI_W-1:0] * 8 +: 8] = r_q.rx_sh;
                        if (r_q.idx == r_q.nb - 1'b1) begin
                            r_d.cs_n = 1'b1;
                            r_d.gap  = 1'b0;
                            r_d.st   = ST_GAP;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (r_q.gap) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.gap = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_o   = r_q.data;
    assign busy_o   = (r_q.st != ST_IDLE);
    assign done_o   = r_q.done;
    assign spi_sck  = r_q.sck;
    assign spi_cs_n = r_q.cs_n;
    assign spi_mosi = !r_q.cs_n && (r_q.idx < r_q.tx_n) && tx_byte[3'd7 - r_q.bit_cnt];
endmodule

module spi_fe_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic sck,
    input logic cs_n,
    input logic mosi
);
    // R5
    idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n);
    // R3
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (sck && $past(sck)) |-> $stable(mosi));
    // R4
    mosi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !mosi);
    // R2
    done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy)));
    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
endmodule

bind spi_flash_engine spi_fe_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .busy (busy_o),
    .done (done_o),
    .sck  (spi_sck),
    .cs_n (spi_cs_n),
    .mosi (spi_mosi)
);

// File: tb/spi_flash_engine_tb.sv
module spi_flash_engine_tb;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] data_o;
    logic        busy_o, done_o, spi_sck, spi_cs_n, spi_mosi, spi_miso;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [7:0] resp [12];
    logic [95:0] cap;
    int bitcnt = 0, sck_cnt = 0, csfall_cnt = 0, done_cnt = 0, gap_cnt = 0;

    always #2 clk = ~clk;

    spi_flash_engine #(.DIV_HALF(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .data_o(data_o), .busy_o(busy_o), .done_o(done_o),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // flash model: returns resp stream, captures MOSI
    assign spi_miso = (bitcnt < 96) ? resp[bitcnt / 8][7 - (bitcnt % 8)] : 1'b0;
    always @(negedge spi_cs_n) begin
        bitcnt = 0;
        csfall_cnt++;
    end
    always @(posedge spi_sck) begin
        if (bitcnt < 96) cap[bitcnt] = spi_mosi;
        bitcnt++;
        sck_cnt++;
    end
    always @(negedge clk) begin
        if (done_o) done_cnt++;
        if (spi_cs_n && busy_o) gap_cnt++;
    end

    function automatic logic [7:0] cap_byte(int k);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) r[7 - b] = cap[k * 8 + b];
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic clear_counts();
        sck_cnt = 0; csfall_cnt = 0; done_cnt = 0; gap_cnt = 0; cap = '0;
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 done", 32'(done_o), 0);
        chk("R1 cs_n", 32'(spi_cs_n), 1);
        chk("R1 sck", 32'(spi_sck), 0);
        chk("R1 data", data_o, 0);
    endtask

    task automatic t_write8();
        logic [7:0] exp [8] = '{8'h02, 8'hA1, 8'hB2, 8'hC3, 8'h11, 8'h22, 8'h33, 8'h44};
        wr(2'd0, 32'hA1B2C3_02);
        wr(2'd1, 32'h44332211);
        chk("R10 data write", data_o, 32'h44332211);
        clear_counts();
        wr(2'd2, 32'h0000_0108);
        chk("R2 busy after start", 32'(busy_o), 1);
        wait_done();
        for (int k = 0; k < 8; k++) chk($sformatf("R3 tx byte %0d", k), 32'(cap_byte(k)), 32'(exp[k]));
        chk("R5 sck edges", sck_cnt, 64);
        chk("R5 cs falls", csfall_cnt, 1);
        chk("R2 done pulses", done_cnt, 1);
        chk("R9 idle gap", gap_cnt, 2 * DIV);
        chk("R4 data kept", data_o, 32'h44332211);
        chk("R2 busy end", 32'(busy_o), 0);
    endtask

    task automatic t_read3();
        resp = '{8'h00, 8'hC2, 8'h20, 8'h17, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        wr(2'd0, 32'h0000009F);
        wr(2'd1, 32'hDEADBEEF);
        clear_counts();
        wr(2'd2, 32'h0000_0131);
        wait_done();
        chk("R3 opcode", 32'(cap_byte(0)), 32'h9F);
        chk("R4 mosi quiet in rx", 32'(cap[31:8]), 0);
        chk("R4 rx packing", data_o, 32'hDE1720C2);
        chk("R5 sck edges rx", sck_cnt, 32);
    endtask

    task automatic t_read4();
        resp = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h5A, 8'hA5, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00};
        wr(2'd0, 32'h00010003);
        clear_counts();
        wr(2'd2, 32'h0000_0144);
        wait_done();
        chk("R3 addr msb", 32'(cap_byte(1)), 32'h00);
        chk("R3 addr mid", 32'(cap_byte(2)), 32'h01);
        chk("R4 rx four", data_o, 32'hF00FA55A);
    endtask

    task automatic t_clamp();
        resp = '{8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h81, 8'h42, 8'h24, 8'h18};
        wr(2'd1, 32'h0);
        clear_counts();
        wr(2'd2, 32'h0000_01FF);
        wait_done();
        chk("R6 clamped length", sck_cnt, 96);
        chk("R6 clamped rx", data_o, 32'h18244281);
    endtask

    task automatic t_zero();
        clear_counts();
        wr(2'd2, 32'h0000_0100);
        repeat (20) @(negedge clk);
        chk("R7 no busy", 32'(busy_o), 0);
        chk("R7 no cs", csfall_cnt, 0);
        chk("R7 no sck", sck_cnt, 0);
    endtask

    task automatic t_nostart();
        clear_counts();
        wr(2'd2, 32'h0000_0048);
        repeat (20) @(negedge clk);
        chk("R10 no start", 32'(busy_o), 0);
        chk("R10 no cs", csfall_cnt, 0);
    endtask

    task automatic t_busy_write();
        wr(2'd0, 32'h55667788);
        wr(2'd1, 32'hCAFEF00D);
        clear_counts();
        wr(2'd2, 32'h0000_0108);
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h12345678);
        wr(2'd2, 32'h0000_0101);
        wait_done();
        chk("R8 data ignored", data_o, 32'hCAFEF00D);
        chk("R8 cmd ignored", 32'(cap_byte(1)), 32'h55);
        chk("R8 data byte sent", 32'(cap_byte(7)), 32'hCA);
        chk("R8 ctrl ignored", sck_cnt, 64);
    endtask

    initial begin
        for (int i = 0; i < 12; i++) resp[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_write8();
        t_read3();
        t_read4();
        t_clamp();
        t_zero();
        t_nostart();
        t_busy_write();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule